// File: doc/BRIEF.md
# Effective Address Unit

This unit sits between the instruction decoder and the memories of a small 8-bit controller core. It turns the addressing mode of the current instruction, its operand byte, the X pointer and the program counter into one 11-bit address. A second output tells whether that address belongs to the data space or the program space. For immediate operands the unit passes the operand byte out on a separate value path and produces no address. Instructions with no operand produce nothing at all.

Long jumps and subroutine calls carry an 11-bit target split across two operand bytes. The decoder presents the first byte with a load strobe, and the unit keeps its low three bits in a register. On a later cycle the decoder presents the second byte in absolute mode, and the unit joins the two bytes into the target. Any mode or opcode-class combination that the core does not allow raises an illegal flag instead of producing an address.

Every output is combinational from the inputs and the stored high bits, so an address is ready in the same cycle that its mode and operand are presented.

Top module: `ea_unit`

## Requirements
- R1: Indexed mode (`mode_i`=0) gives `addr_o` = (`xptr_i`[10:0] + `opnd_i`) mod 2048, with the offset read as unsigned. X bits above bit 10 are ignored. `prog_space_o` follows `sel_prog_i` and `addr_vld_o`=1.
- R2: Indirect mode (`mode_i`=1) gives `addr_o` = `xptr_i`[10:0] with `prog_space_o`=0 and `addr_vld_o`=1.
- R3: Direct mode (`mode_i`=2) gives `addr_o` = `opnd_i` zero-extended, with `prog_space_o`=0 and `addr_vld_o`=1.
- R4: Immediate mode (`mode_i`=3) gives `imm_o`=`opnd_i` and `imm_vld_o`=1, with `addr_vld_o`=0 and `addr_o`=0. In every other mode `imm_o`=0 and `imm_vld_o`=0.
- R5: A clock edge with `hi_ld_i`=1 stores `opnd_i`[2:0]. Absolute mode (`mode_i`=5) with `cls_i`=1 (long jump) or `cls_i`=2 (call) gives `addr_o` = {stored bits, `opnd_i`}, with `prog_space_o`=1 and `addr_vld_o`=1.
- R6: Absolute mode with `cls_i`=0 or 3 sets `illegal_o`=1 and `addr_vld_o`=0.
- R7: Relative mode (`mode_i`=6) gives `addr_o` = (`pc_i` + `opnd_i`[5:0] − 31) mod 2048, so the field values 0..63 reach −31..+32. `opnd_i`[7:6] are ignored. It also gives `prog_space_o`=1 and `addr_vld_o`=1.
- R8: Inherent mode (`mode_i`=4) drives `addr_vld_o`, `imm_vld_o` and `illegal_o` to 0 and `addr_o` to 0.
- R9: The reserved mode value 7 sets `illegal_o`=1 and `addr_vld_o`=0.
- R10: A synchronous reset (`rst_i`=1) clears the stored high bits to 0.
- R11: At most one of `addr_vld_o`, `imm_vld_o` and `illegal_o` is 1. Whenever `addr_vld_o`=0, `addr_o` and `prog_space_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing mode code |
| cls_i | input | 2 | Opcode class: 0/3 other, 1 long jump, 2 call |
| opnd_i | input | 8 | Current operand byte |
| xptr_i | input | 12 | X pointer register |
| pc_i | input | 11 | Current program counter |
| sel_prog_i | input | 1 | Space select for indexed mode (1 = program) |
| hi_ld_i | input | 1 | Store first byte of an absolute target |
| addr_o | output | 11 | Effective address or jump target |
| addr_vld_o | output | 1 | An address is produced |
| prog_space_o | output | 1 | Address lies in program space |
| imm_o | output | 8 | Immediate operand value |
| imm_vld_o | output | 1 | Immediate value is produced |
| illegal_o | output | 1 | Mode not allowed for this instruction |

## Verification
The assertions check several rules on every cycle: that no more than one result kind is active, that inherent mode stays quiet, that data-only modes never select program space, and that absolute mode with a disallowed class is flagged. They also check that a relative target always lies within −31..+32 of the PC, and that a loaded high part shows up in the next absolute target. The exact sums need the bench's scenarios, including the carry dropped out of bit 10 in indexed mode, the wrap below zero and above 2047 in relative mode, and the X bits above bit 10 being ignored. The same holds for the register being cleared by reset and for operand bits 7:6 being ignored in relative mode.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 8;
    localparam int XPTR_W  = 12;
    localparam int REL_W   = 6;
    localparam int REL_BIAS = 31;

    typedef enum logic [2:0] {
        MODE_INDEXED  = 3'd0,
        MODE_INDIRECT = 3'd1,
        MODE_DIRECT   = 3'd2,
        MODE_IMMED    = 3'd3,
        MODE_INHERENT = 3'd4,
        MODE_ABSOLUTE = 3'd5,
        MODE_RELATIVE = 3'd6,
        MODE_RESERVED = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        CLS_OTHER_A = 2'd0,
        CLS_LONGJMP = 2'd1,
        CLS_CALL    = 2'd2,
        CLS_OTHER_B = 2'd3
    } ea_cls_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_INDEX,
        SRC_XPTR,
        SRC_DIRECT,
        SRC_ABS,
        SRC_REL
    } ea_src_e;

    typedef struct packed {
        ea_src_e src;
        logic    prog;
        logic    imm;
        logic    illegal;
    } ea_ctl_t;

    function automatic logic cls_may_jump(input ea_cls_e c);
        return (c == CLS_LONGJMP) || (c == CLS_CALL);
    endfunction

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic [1:0] cls_i,
    input  logic       sel_prog_i,
    output ea_ctl_t    ctl_o
);

    ea_mode_e mode;
    ea_cls_e  cls;

    assign mode = ea_mode_e'(mode_i);
    assign cls  = ea_cls_e'(cls_i);

    always_comb begin
        ctl_o = '{src: SRC_NONE, prog: 1'b0, imm: 1'b0, illegal: 1'b0};
        case (mode)
            MODE_INDEXED: begin
                ctl_o.src  = SRC_INDEX;
                ctl_o.prog = sel_prog_i;
            end
            MODE_INDIRECT: ctl_o.src = SRC_XPTR;
            MODE_DIRECT:   ctl_o.src = SRC_DIRECT;
            MODE_IMMED:    ctl_o.imm = 1'b1;
            MODE_INHERENT: ctl_o.src = SRC_NONE;
            MODE_ABSOLUTE: begin
                if (cls_may_jump(cls)) begin
                    ctl_o.src  = SRC_ABS;
                    ctl_o.prog = 1'b1;
                end else begin
                    ctl_o.illegal = 1'b1;
                end
            end
            MODE_RELATIVE: begin
                ctl_o.src  = SRC_REL;
                ctl_o.prog = 1'b1;
            end
            default: ctl_o.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/ea_wrap_add.sv
module ea_wrap_add #(
    parameter int AW   = 11,
    parameter int OW   = 8,
    parameter int BIAS = 0
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] sum_o
);

    localparam int PAD_W = AW - OW;

    logic [AW-1:0] off_ext;
    assign off_ext = {{PAD_W{1'b0}}, off_i};

    generate
        if (BIAS == 0) begin : g_plain
            assign sum_o = base_i + off_ext;
        end else begin : g_biased
            localparam logic [AW-1:0] BIAS_V = AW'(BIAS);
            assign sum_o = base_i + off_ext - BIAS_V;
        end
    endgenerate

endmodule

// File: rtl/ea_hi_reg.sv
module ea_hi_reg #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else if (ld_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int XW = XPTR_W,
    parameter int RW = REL_W,
    parameter int RB = REL_BIAS
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [2:0]    mode_i,
    input  logic [1:0]    cls_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [XW-1:0] xptr_i,
    input  logic [AW-1:0] pc_i,
    input  logic          sel_prog_i,
    input  logic          hi_ld_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_vld_o,
    output logic          prog_space_o,
    output logic [DW-1:0] imm_o,
    output logic          imm_vld_o,
    output logic          illegal_o
);

    localparam int HI_W = AW - DW;

    ea_ctl_t       ctl;
    logic [AW-1:0] x_low;
    logic [AW-1:0] idx_sum;
    logic [AW-1:0] rel_sum;
    logic [HI_W-1:0] hi_q;
    logic          unused_xhi;

    assign x_low      = xptr_i[AW-1:0];
    assign unused_xhi = ^xptr_i[XW-1:AW];

    ea_mode_dec u_dec (
        .mode_i     (mode_i),
        .cls_i      (cls_i),
        .sel_prog_i (sel_prog_i),
        .ctl_o      (ctl)
    );

    ea_wrap_add #(.AW(AW), .OW(DW), .BIAS(0)) u_idx_add (
        .base_i (x_low),
        .off_i  (opnd_i),
        .sum_o  (idx_sum)
    );

    ea_wrap_add #(.AW(AW), .OW(RW), .BIAS(RB)) u_rel_add (
        .base_i (pc_i),
        .off_i  (opnd_i[RW-1:0]),
        .sum_o  (rel_sum)
    );

    ea_hi_reg #(.W(HI_W)) u_hi (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ld_i  (hi_ld_i),
        .d_i   (opnd_i[HI_W-1:0]),
        .q_o   (hi_q)
    );

    always_comb begin
        addr_o     = '0;
        addr_vld_o = 1'b1;
        case (ctl.src)
            SRC_INDEX:  addr_o = idx_sum;
            SRC_XPTR:   addr_o = x_low;
            SRC_DIRECT: addr_o = {{HI_W{1'b0}}, opnd_i};
            SRC_ABS:    addr_o = {hi_q, opnd_i};
            SRC_REL:    addr_o = rel_sum;
            default:    addr_vld_o = 1'b0;
        endcase
    end

    assign prog_space_o = ctl.prog & addr_vld_o;
    assign imm_vld_o    = ctl.imm;
    assign imm_o        = ctl.imm ? opnd_i : '0;
    assign illegal_o    = ctl.illegal;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [2:0]    mode_i,
    input logic [1:0]    cls_i,
    input logic [DW-1:0] opnd_i,
    input logic [AW-1:0] pc_i,
    input logic          hi_ld_i,
    input logic [AW-1:0] addr_o,
    input logic          addr_vld_o,
    input logic          prog_space_o,
    input logic [DW-1:0] imm_o,
    input logic          imm_vld_o,
    input logic          illegal_o
);

    localparam int HI_W = AW - DW;
    localparam logic [AW-1:0] FWD_MAX = AW'(32);
    localparam logic [AW-1:0] BACK_MIN = AW'((1 << AW) - 31);

    logic [AW-1:0] rel_dist;
    logic          abs_ok;
    assign rel_dist = addr_o - pc_i;
    assign abs_ok   = (mode_i == 3'd5) && ((cls_i == 2'd1) || (cls_i == 2'd2));

    AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({addr_vld_o, imm_vld_o, illegal_o})) else $error("one result"); // R11

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !addr_vld_o |-> (addr_o == '0 && !prog_space_o)) else $error("idle addr"); // R11

    AST_INHERENT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd4) |-> (!addr_vld_o && !imm_vld_o && !illegal_o)) else $error("inherent"); // R8

    AST_DATA_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd1 || mode_i == 3'd2) |-> (addr_vld_o && !prog_space_o)) else $error("data space"); // R2

    AST_IMM_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd3) |-> (imm_vld_o && imm_o == opnd_i && !addr_vld_o)) else $error("immediate"); // R4

    AST_ABS_CLASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd5 && !abs_ok) |-> (illegal_o && !addr_vld_o)) else $error("abs class"); // R6

    AST_ABS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        hi_ld_i |=> (!abs_ok || addr_o[AW-1:DW] == $past(opnd_i[HI_W-1:0]))) else $error("abs high"); // R5

    AST_REL_REACH: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd6) |-> (prog_space_o && (rel_dist <= FWD_MAX || rel_dist >= BACK_MIN))) else $error("rel reach"); // R7

    AST_RESERVED_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 3'd7) |-> (illegal_o && !addr_vld_o)) else $error("reserved"); // R9

endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .mode_i       (mode_i),
    .cls_i        (cls_i),
    .opnd_i       (opnd_i),
    .pc_i         (pc_i),
    .hi_ld_i      (hi_ld_i),
    .addr_o       (addr_o),
    .addr_vld_o   (addr_vld_o),
    .prog_space_o (prog_space_o),
    .imm_o        (imm_o),
    .imm_vld_o    (imm_vld_o),
    .illegal_o    (illegal_o)
);

// File: tb/ea_unit_tb_top.sv
`timescale 1ns/1ps
module ea_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode;
    logic [1:0]  cls;
    logic [7:0]  opnd;
    logic [11:0] xptr;
    logic [10:0] pc;
    logic        sel_prog;
    logic        hi_ld;
    logic [10:0] addr;
    logic        addr_vld;
    logic        prog_sp;
    logic [7:0]  imm;
    logic        imm_vld;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ea_unit dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .mode_i       (mode),
        .cls_i        (cls),
        .opnd_i       (opnd),
        .xptr_i       (xptr),
        .pc_i         (pc),
        .sel_prog_i   (sel_prog),
        .hi_ld_i      (hi_ld),
        .addr_o       (addr),
        .addr_vld_o   (addr_vld),
        .prog_space_o (prog_sp),
        .imm_o        (imm),
        .imm_vld_o    (imm_vld),
        .illegal_o    (illegal)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns later
    task automatic apply(input logic [2:0] m, input logic [1:0] c, input logic [7:0] o,
                         input logic [11:0] x, input logic [10:0] p, input logic sp);
        @(negedge clk);
        mode = m; cls = c; opnd = o; xptr = x; pc = p; sel_prog = sp; hi_ld = 1'b0;
        #1;
    endtask

    task automatic load_hi(input logic [7:0] b);
        @(negedge clk);
        mode = 3'd4; opnd = b; hi_ld = 1'b1;
        @(negedge clk);
        hi_ld = 1'b0;
    endtask

    task automatic expect_addr(input string tag, input int a, input bit p);
        check({tag, " addr"}, addr, a);
        check({tag, " valid"}, addr_vld, 1);
        check({tag, " space"}, prog_sp, p);
        check({tag, " imm_vld"}, imm_vld, 0);
        check({tag, " illegal"}, illegal, 0);
    endtask

    task automatic t_reset();
        // a load attempted under reset must not stick
        @(negedge clk);
        rst = 1'b1; hi_ld = 1'b1; opnd = 8'h07; mode = 3'd4;
        repeat (3) @(negedge clk);
        rst = 1'b0; hi_ld = 1'b0;
        apply(3'd5, 2'd1, 8'h34, 12'h0, 11'h0, 1'b0);
        expect_addr("R10 reset high bits", 11'h034, 1'b1);
        load_hi(8'h06);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply(3'd5, 2'd2, 8'hAA, 12'h0, 11'h0, 1'b0);
        expect_addr("R10 reset clears load", 11'h0AA, 1'b1);
    endtask

    task automatic t_indexed();
        apply(3'd0, 2'd0, 8'h45, 12'h123, 11'h0, 1'b0);
        expect_addr("R1 indexed data", 11'h168, 1'b0);
        apply(3'd0, 2'd0, 8'h20, 12'hFF0, 11'h0, 1'b1);
        expect_addr("R1 indexed wrap prog", 11'h010, 1'b1);
        apply(3'd0, 2'd0, 8'hFF, 12'h800, 11'h0, 1'b0);
        expect_addr("R1 indexed high x ignored", 11'h0FF, 1'b0);
    endtask

    task automatic t_indirect();
        apply(3'd1, 2'd0, 8'h11, 12'h9AB, 11'h0, 1'b1);
        expect_addr("R2 indirect", 11'h1AB, 1'b0);
    endtask

    task automatic t_direct();
        apply(3'd2, 2'd0, 8'hC7, 12'h555, 11'h0, 1'b1);
        expect_addr("R3 direct", 11'h0C7, 1'b0);
    endtask

    task automatic t_immediate();
        apply(3'd3, 2'd0, 8'h5A, 12'h123, 11'h0, 1'b1);
        check("R4 imm value", imm, 8'h5A);
        check("R4 imm valid", imm_vld, 1);
        check("R4 no addr", addr_vld, 0);
        check("R4 addr zero", addr, 0);
        apply(3'd2, 2'd0, 8'h5A, 12'h0, 11'h0, 1'b0);
        check("R4 imm zero elsewhere", imm, 0);
    endtask

    task automatic t_absolute();
        load_hi(8'hFD);
        apply(3'd5, 2'd1, 8'h9E, 12'h0, 11'h0, 1'b0);
        expect_addr("R5 long jump", 11'h59E, 1'b1);
        apply(3'd5, 2'd2, 8'h01, 12'h0, 11'h0, 1'b0);
        expect_addr("R5 call", 11'h501, 1'b1);
        apply(3'd5, 2'd0, 8'h01, 12'h0, 11'h0, 1'b0);
        check("R6 class 0 illegal", illegal, 1);
        check("R6 class 0 no addr", addr_vld, 0);
        apply(3'd5, 2'd3, 8'h01, 12'h0, 11'h0, 1'b0);
        check("R6 class 3 illegal", illegal, 1);
        check("R6 class 3 no addr", addr_vld, 0);
    endtask

    task automatic t_relative();
        apply(3'd6, 2'd0, 8'h1F, 12'h0, 11'h100, 1'b0);
        expect_addr("R7 rel zero", 11'h100, 1'b1);
        apply(3'd6, 2'd0, 8'hDF, 12'h0, 11'h100, 1'b0);
        expect_addr("R7 rel top bits ignored", 11'h100, 1'b1);
        apply(3'd6, 2'd0, 8'h3F, 12'h0, 11'h7F0, 1'b0);
        expect_addr("R7 rel +32 wrap", 11'h010, 1'b1);
        apply(3'd6, 2'd0, 8'h00, 12'h0, 11'h010, 1'b0);
        expect_addr("R7 rel -31 wrap", 11'h7F1, 1'b1);
    endtask

    task automatic t_inherent();
        apply(3'd4, 2'd1, 8'hFF, 12'hFFF, 11'h7FF, 1'b1);
        check("R8 no addr", addr_vld, 0);
        check("R8 addr zero", addr, 0);
        check("R8 no imm", imm_vld, 0);
        check("R8 no illegal", illegal, 0);
        check("R11 space zero", prog_sp, 0);
    endtask

    task automatic t_reserved();
        apply(3'd7, 2'd1, 8'h12, 12'h0, 11'h0, 1'b1);
        check("R9 reserved illegal", illegal, 1);
        check("R9 reserved no addr", addr_vld, 0);
        check("R11 reserved addr zero", addr, 0);
    endtask

    initial begin
        rst = 1'b1; mode = 3'd4; cls = 2'd0; opnd = '0; xptr = '0;
        pc = '0; sel_prog = 1'b0; hi_ld = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_indexed();
        t_indirect();
        t_direct();
        t_immediate();
        t_absolute();
        t_relative();
        t_inherent();
        t_reserved();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule